// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration-space front end of a legacy-style I/O peripheral. A host reaches it through two byte-wide I/O addresses. The even address is the index port and selects a register. The odd address is the data port and reads or writes the selected register. The pair sits at a base address set by a parameter, either 0x2E or 0x4E, so two copies can share one I/O bus.

The register space stays locked after reset. It opens only when the host writes an unlock key to the index port twice in a row, and it closes again when the host writes an exit key to the same port. While the space is open, the low indexes hold a few global registers: a bank selector, a read-only device identifier and an options byte. Every index from 0x30 upward is passed on to an attached device bank, together with the current bank selector value. The bank receives single-cycle read and write strobes.

Top module: `cfgp_port`

## Requirements
- R1: After a synchronous active-low reset the space is locked. Reads of both the index address and the data address return 0xFF. The index, bank selector and options registers all reset to 0x00.
- R2: Two consecutive index-port writes of 0x87 open the space. Once open, a read of the index address returns the currently latched index.
- R3: While the first 0x87 is pending, an index-port write of any other value drops the sequence back to its start. A further pair of 0x87 writes is then needed.
- R4: While the space is open, an index-port write of 0xAA locks it again and leaves the latched index unchanged. For this reason 0xAA can never be selected as an index.
- R5: While the space is locked, data-port writes change no register and produce no bank strobe.
- R6: While the space is open, every index-port write other than 0xAA, including 0x87, is latched as the new index.
- R7: Index 0x20 reads the high byte and index 0x21 the low byte of the CHIP_ID parameter (default 0x1061). Writes to these two indexes are ignored.
- R8: Index 0x26 is an 8-bit options register that can be read and written.
- R9: Index 0x07 is an 8-bit bank selector that can be read and written. Its value is presented to the bank on bank_ldn.
- R10: At an index of 0x30 or above, a data-port write raises bank_wr for exactly that cycle, with bank_idx, bank_ldn and bank_wdata valid. A data-port read raises bank_rd, and io_rdata then returns bank_rdata.
- R11: Indexes below 0x30 other than 0x07, 0x20, 0x21 and 0x26 read as 0x00, ignore writes and produce no bank strobe.
- R12: The block decodes only BASE_ADDR (index) and BASE_ADDR+1 (data). Every other address reads 0xFF and has no effect, including when the value written is a key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| bank_wr | output | 1 | Write strobe toward the device bank |
| bank_rd | output | 1 | Read strobe toward the device bank |
| bank_idx | output | 8 | Register index for the bank access |
| bank_ldn | output | 8 | Current bank selector value |
| bank_wdata | output | 8 | Write data toward the bank |
| bank_rdata | input | 8 | Read data from the bank, combinational on bank_rd |

## Verification
The assertions take for granted that the host never raises io_rd and io_wr in the same cycle. They also take for granted that bank_rdata settles within the cycle of bank_rd. The bench drives one strobe at a time and holds it for exactly one clock. Its bank model computes the read data combinationally from bank_idx and bank_ldn. The bench sweeps every selectable index and uses two instances at both legal base addresses on the same bus, so every key write also tests that the other instance ignores it.

// File: rtl/cfgp_pkg.sv
// Shared constants and types of the keyed configuration port.
// Assumes byte-wide data; keys and global indexes are fixed byte codes.
package cfgp_pkg;
    localparam int          DW            = 8;
    localparam logic [7:0]  KEY_ENTER     = 8'h87;
    localparam logic [7:0]  KEY_EXIT      = 8'hAA;
    localparam logic [7:0]  IDX_LDN       = 8'h07;
    localparam logic [7:0]  IDX_ID_HI     = 8'h20;
    localparam logic [7:0]  IDX_ID_LO     = 8'h21;
    localparam logic [7:0]  IDX_OPTS      = 8'h26;
    localparam logic [7:0]  IDX_BANK_BASE = 8'h30;
    localparam logic [7:0]  BUS_IDLE      = 8'hFF;

    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_t;
endpackage

// File: rtl/cfgp_decode.sv
// Address decode for the index/data port pair.
// Assumes BASE_ADDR is even; bit 0 of the address picks index (0) or data (1).
module cfgp_decode #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2E
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              hit,
    output logic              sel_data,
    output logic              idx_wr,
    output logic              dat_wr,
    output logic              dat_rd
);
    localparam logic [ADDR_W-2:0] PAIR = BASE_ADDR[ADDR_W-1:1];

    // Match the upper address bits against the port pair and split by bit 0.
    always_comb begin
        hit      = (io_addr[ADDR_W-1:1] == PAIR);
        sel_data = io_addr[0];
        idx_wr   = io_wr & hit & ~sel_data;
        dat_wr   = io_wr & hit &  sel_data;
        dat_rd   = io_rd & hit &  sel_data;
    end
endmodule

// File: rtl/cfgp_unlock.sv
// Lock state machine: two back-to-back enter keys open the space,
// the exit key closes it. Only index-port writes move the state.
module cfgp_unlock
    import cfgp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          is_open,
    output logic          idx_take
);
    lock_state_t st;

    // Advance the key sequence on each index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LK_SHUT;
        end else if (idx_wr) begin
            case (st)
                LK_SHUT: st <= (wdata == KEY_ENTER) ? LK_HALF : LK_SHUT;
                LK_HALF: st <= (wdata == KEY_ENTER) ? LK_OPEN : LK_SHUT;
                LK_OPEN: st <= (wdata == KEY_EXIT)  ? LK_SHUT : LK_OPEN;
                default: st <= LK_SHUT;
            endcase
        end
    end

    // Expose the open flag and which index writes are to be latched.
    always_comb begin
        is_open  = (st == LK_OPEN);
        idx_take = idx_wr & is_open & (wdata != KEY_EXIT);
    end

    // R2: the space only opens right after a second enter key.
    p_open_two_keys_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_OPEN && $past(st) != LK_OPEN) |->
            $past(st == LK_HALF && idx_wr && wdata == KEY_ENTER));

    // R3: a wrong value after the first key restarts the sequence.
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_HALF && idx_wr && wdata != KEY_ENTER) |=> (st == LK_SHUT));

    // R4: the exit key locks the space.
    p_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LK_OPEN && idx_wr && wdata == KEY_EXIT) |=> (st == LK_SHUT));
endmodule

// File: rtl/cfgp_regs.sv
// Index latch, global registers and bank forwarding.
// Assumes write strobes arrive already qualified by the open state.
module cfgp_regs
    import cfgp_pkg::*;
#(
    parameter logic [15:0] CHIP_ID = 16'h1061
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_take,
    input  logic          dat_wr_ok,
    input  logic          dat_rd_ok,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bank_rdata,
    output logic [DW-1:0] cur_idx,
    output logic [DW-1:0] rd_val,
    output logic          bank_wr,
    output logic          bank_rd,
    output logic [DW-1:0] bank_ldn
);
    logic [DW-1:0] ldn_q;
    logic [DW-1:0] opts_q;
    logic          in_bank;

    assign in_bank  = (cur_idx >= IDX_BANK_BASE);
    assign bank_ldn = ldn_q;

    // Latch the selected index.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_idx <= '0;
        else if (idx_take) cur_idx <= wdata;
    end

    // Update writable global registers on data-port writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q  <= '0;
            opts_q <= '0;
        end else if (dat_wr_ok && !in_bank) begin
            if (cur_idx == IDX_LDN)  ldn_q  <= wdata;
            if (cur_idx == IDX_OPTS) opts_q <= wdata;
        end
    end

    // Read mux and bank strobes.
    always_comb begin
        bank_wr = dat_wr_ok & in_bank;
        bank_rd = 1'b0;
        rd_val  = '0;
        if (in_bank) begin
            bank_rd = dat_rd_ok;
            rd_val  = bank_rdata;
        end else begin
            case (cur_idx)
                IDX_LDN:   rd_val = ldn_q;
                IDX_ID_HI: rd_val = CHIP_ID[15:8];
                IDX_ID_LO: rd_val = CHIP_ID[7:0];
                IDX_OPTS:  rd_val = opts_q;
                default:   rd_val = '0;
            endcase
        end
    end

    // R9: the bank selector holds unless written through its own index.
    p_ldn_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_wr_ok && cur_idx == IDX_LDN) |=> $stable(ldn_q));

    // R8: the options byte holds unless written through its own index.
    p_opts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dat_wr_ok && cur_idx == IDX_OPTS) |=> $stable(opts_q));

    // R10: never both bank strobes at once (host keeps rd and wr exclusive).
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_wr, bank_rd}));
endmodule

// File: rtl/cfgp_port.sv
// Keyed index/data configuration port, top level.
// Assumes one strobe per cycle and a bank that answers reads combinationally.
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h2E,
    parameter logic [15:0]       CHIP_ID   = 16'h1061
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              bank_wr,
    output logic              bank_rd,
    output logic [7:0]        bank_idx,
    output logic [7:0]        bank_ldn,
    output logic [7:0]        bank_wdata,
    input  logic [7:0]        bank_rdata
);
    logic          hit, sel_data, idx_wr, dat_wr, dat_rd;
    logic          is_open, idx_take;
    logic [DW-1:0] cur_idx, rd_val;

    cfgp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .hit(hit), .sel_data(sel_data),
        .idx_wr(idx_wr), .dat_wr(dat_wr), .dat_rd(dat_rd)
    );

    cfgp_unlock u_lock (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
        .is_open(is_open), .idx_take(idx_take)
    );

    cfgp_regs #(.CHIP_ID(CHIP_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .idx_take(idx_take),
        .dat_wr_ok(dat_wr & is_open), .dat_rd_ok(dat_rd & is_open),
        .wdata(io_wdata), .bank_rdata(bank_rdata),
        .cur_idx(cur_idx), .rd_val(rd_val),
        .bank_wr(bank_wr), .bank_rd(bank_rd), .bank_ldn(bank_ldn)
    );

    assign bank_idx   = cur_idx;
    assign bank_wdata = io_wdata;

    // Return data: idle bus when not addressed or locked.
    always_comb begin
        if (!hit || !is_open) io_rdata = BUS_IDLE;
        else if (!sel_data)   io_rdata = cur_idx;
        else                  io_rdata = rd_val;
    end

    // R1: a locked block answers every read with the idle value.
    p_locked_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open && io_rd) |-> (io_rdata == BUS_IDLE));

    // R5: no bank traffic while locked.
    p_no_bank_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !is_open |-> (!bank_wr && !bank_rd));

    // R12: accesses outside the pair never reach the bank.
    p_decode_only_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr[ADDR_W-1:1] != BASE_ADDR[ADDR_W-1:1]) |-> (!bank_wr && !bank_rd));
endmodule

// File: tb/tb_cfgp_port.sv
module tb_cfgp_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  rd_a, rd_b;
    logic        bw_a, br_a, bw_b, br_b;
    logic [7:0]  bi_a, bl_a, bd_a, bi_b, bl_b, bd_b;
    logic [7:0]  bank_rdata_a;

    int n_chk = 0, n_bad = 0, n_bw = 0;
    logic [7:0] last_bi, last_bl, last_bd;
    bit done = 0;

    always #10 clk = ~clk;

    // Bank model: read data is a pure function of index and selector.
    assign bank_rdata_a = br_a ? (bi_a ^ bl_a ^ 8'h5A) : 8'h00;

    cfgp_port #(.BASE_ADDR(16'h002E)) dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rd_a), .bank_wr(bw_a), .bank_rd(br_a),
        .bank_idx(bi_a), .bank_ldn(bl_a), .bank_wdata(bd_a), .bank_rdata(bank_rdata_a)
    );

    cfgp_port #(.BASE_ADDR(16'h004E)) dut_alt (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(rd_b), .bank_wr(bw_b), .bank_rd(br_b),
        .bank_idx(bi_b), .bank_ldn(bl_b), .bank_wdata(bd_b), .bank_rdata(8'h00)
    );

    always @(posedge clk) if (bw_a) begin
        n_bw++;
        last_bi <= bi_a; last_bl <= bl_a; last_bd <= bd_a;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic brs);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #3;
        v   = (a[15:1] == 16'h0027) ? rd_b : rd_a;
        brs = br_a;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    function automatic logic [7:0] expv(input logic [7:0] i, input logic [7:0] ldn,
                                        input logic [7:0] opt);
        if (i == 8'h07) return ldn;
        if (i == 8'h20) return 8'h10;
        if (i == 8'h21) return 8'h61;
        if (i == 8'h26) return opt;
        if (i >= 8'h30) return i ^ ldn ^ 8'h5A;
        return 8'h00;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=00 expected=01");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic b;
        int bw_snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: locked after reset
        rd(16'h002E, v, b); chk("R1 index idle", v, 8'hFF);
        rd(16'h002F, v, b); chk("R1 data idle", v, 8'hFF);

        // R12: keys to the other pair open only that instance
        wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
        rd(16'h004E, v, b); chk("R12 alt open index", v, 8'h00);
        rd(16'h002E, v, b); chk("R12 main still locked", v, 8'hFF);
        wr(16'h0030, 8'h87); wr(16'h0030, 8'h87);
        rd(16'h002E, v, b); chk("R12 off-pair keys ignored", v, 8'hFF);
        rd(16'h0030, v, b); chk("R12 off-pair read", v, 8'hFF);

        // R5: locked data writes ignored
        wr(16'h002F, 8'h55);
        chk("R5 no bank write locked", 8'(n_bw), 8'd0);

        // R3: wrong value between keys restarts
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h55); wr(16'h002E, 8'h87);
        rd(16'h002F, v, b); chk("R3 restart stays locked", v, 8'hFF);
        // R2: second key now completes the pair
        wr(16'h002E, 8'h87);
        rd(16'h002E, v, b); chk("R2 open index reads reset", v, 8'h00);

        // R6: index latch, including the enter key value
        wr(16'h002E, 8'h87);
        rd(16'h002E, v, b); chk("R6 key value latched as index", v, 8'h87);
        wr(16'h002E, 8'h26);
        rd(16'h002E, v, b); chk("R6 index readback", v, 8'h26);

        // R8: options
        rd(16'h002F, v, b); chk("R8 opts reset", v, 8'h00);
        wr(16'h002F, 8'hA5);
        rd(16'h002F, v, b); chk("R8 opts write", v, 8'hA5);

        // R9 / R5: bank selector, untouched by locked write
        wr(16'h002E, 8'h07);
        rd(16'h002F, v, b); chk("R5 R9 ldn unchanged", v, 8'h00);
        wr(16'h002F, 8'h03);
        rd(16'h002F, v, b); chk("R9 ldn write", v, 8'h03);

        // R7: identifier read-only
        wr(16'h002E, 8'h20); wr(16'h002F, 8'hFF);
        rd(16'h002F, v, b); chk("R7 id high", v, 8'h10);
        wr(16'h002E, 8'h21); wr(16'h002F, 8'h00);
        rd(16'h002F, v, b); chk("R7 id low", v, 8'h61);

        // R10: bank write forwarding
        wr(16'h002E, 8'h40); wr(16'h002F, 8'h9C);
        chk("R10 bank wr count", 8'(n_bw), 8'd1);
        chk("R10 bank idx", last_bi, 8'h40);
        chk("R10 bank ldn", last_bl, 8'h03);
        chk("R10 bank data", last_bd, 8'h9C);

        // R10 / R11: sweep every selectable index
        for (int i = 0; i < 256; i++) begin
            if (i == 8'hAA) continue;
            wr(16'h002E, 8'(i));
            rd(16'h002F, v, b);
            chk("R10 R11 sweep value", v, expv(8'(i), 8'h03, 8'hA5));
            chk("R10 R11 sweep bank_rd", {7'd0, b}, {7'd0, (i >= 8'h30)});
        end

        // R11: writes to unused globals ignored, no bank strobes
        bw_snap = n_bw;
        for (int i = 0; i < 8'h30; i++) begin
            if (i == 8'h07 || i == 8'h26) continue;
            wr(16'h002E, 8'(i)); wr(16'h002F, 8'hC3);
        end
        chk("R11 no bank writes", 8'(n_bw - bw_snap), 8'd0);
        wr(16'h002E, 8'h11);
        rd(16'h002F, v, b); chk("R11 unused reads zero", v, 8'h00);
        wr(16'h002E, 8'h07);
        rd(16'h002F, v, b); chk("R11 ldn intact", v, 8'h03);
        wr(16'h002E, 8'h26);
        rd(16'h002F, v, b); chk("R11 opts intact", v, 8'hA5);

        // R4: exit key locks, index kept
        wr(16'h002E, 8'hAA);
        rd(16'h002E, v, b); chk("R4 locked index", v, 8'hFF);
        rd(16'h002F, v, b); chk("R4 locked data", v, 8'hFF);
        wr(16'h002F, 8'h44);
        chk("R5 no bank write after exit", 8'(n_bw - bw_snap), 8'd0);
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
        rd(16'h002E, v, b); chk("R4 index kept over exit", v, 8'h26);
        rd(16'h002F, v, b); chk("R5 opts unchanged by locked write", v, 8'hA5);

        finish_run();
    end
endmodule